// File: doc/BRIEF.md
# Branch Target Buffer

This block gives the fetch stage a predicted next PC in the same cycle that it presents a fetch address. The storage is fully associative and holds only branches that were taken. Each entry records the complete branch address, the target it jumped to and a small confidence counter. A fetch address that equals a stored branch address exactly yields the stored target. Any other fetch address yields the sequential address, PC+4. Because the full address is compared, the buffer never hands out a target that belongs to a different branch.

A second port takes branch outcomes from the back of the pipeline. A taken branch that was not held is written into the buffer. A held branch that falls through is removed. A held branch whose target changed has its target rewritten where it sits. In each of these three cases the block raises a redirect strobe, in the same cycle, with the address where fetch must restart. A correctly predicted branch raises no redirect and only strengthens its counter. New entries go into the lowest-numbered free slot. When no slot is free, the slot to overwrite is chosen by a round-robin pointer.

Top module: `btb_core`

## Requirements
- R1: Synchronous active-low reset invalidates every entry. After reset, every lookup misses and reports `lk_state` 0.
- R2: A lookup whose `lk_pc` equals a valid entry's stored branch address in all PC_W bits raises `lk_hit`. It drives `lk_next_pc` with that entry's stored target.
- R3: A lookup that matches no valid entry drives `lk_hit` low and `lk_next_pc` = `lk_pc` + 4. This holds even when the address differs from a stored one in a single bit.
- R4: A resolve with `rs_taken`=1 for an address not held allocates an entry holding that address, its target and counter value 1. In the same cycle it raises `fl_redirect` with `fl_pc` = `rs_target`.
- R5: A resolve with `rs_taken`=0 for a held address deletes that entry. In the same cycle it raises `fl_redirect` with `fl_pc` = `rs_pc` + 4.
- R6: A resolve with `rs_taken`=1 for a held address whose `rs_target` differs from the stored target rewrites that entry's target in place and sets its counter to 1. In the same cycle it raises `fl_redirect` with `fl_pc` = `rs_target`.
- R7: A resolve with `rs_taken`=1 for a held address and the same target raises no redirect. It increments the entry's counter, which saturates at its maximum and is read back on `lk_state` during a hit.
- R8: A resolve with `rs_taken`=0 for an address not held changes nothing and raises no redirect.
- R9: An allocation uses the lowest-indexed invalid entry. When every entry is valid, it overwrites the entry named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, after each such overwrite.
- R10: No branch address is ever held by more than one valid entry.
- R11: While `rs_valid` is low, the resolve inputs have no effect on the table and `fl_redirect` stays low.
- R12: Table changes made by a resolve become visible to lookups from the next clock cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | PC_W | Fetch address being looked up |
| lk_hit | output | 1 | Fetch address matches a held branch |
| lk_next_pc | output | PC_W | Predicted next fetch address |
| lk_state | output | CNT_W | Confidence counter of the hit entry, 0 on a miss |
| rs_valid | input | 1 | A branch outcome is presented this cycle |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_taken | input | 1 | Resolved direction, 1 = taken |
| rs_target | input | PC_W | Resolved target address |
| fl_redirect | output | 1 | Fetch was wrong and must restart |
| fl_pc | output | PC_W | Restart address for fetch |

## Verification
The hardest state to reach from the ports is a full table that also has a hole in it. Reaching it takes several steps: fill every entry, delete one, then allocate twice, so that the first allocation takes the hole and the second replaces the entry under the round-robin pointer. A directed sequence builds this state and then checks which addresses still hit. After that, random resolves drawn from a pool of addresses larger than the table, each address with two possible targets, keep the table churning through every resolve case. Each step is compared against a bench model of the table.

// File: rtl/btb_pkg.sv
// Shared definitions for the branch target buffer.
// Assumes: consumers import the package; nothing here is configurable.
package btb_pkg;

    // Action chosen for one resolve-port update.
    typedef enum logic [2:0] {
        ACT_NONE     = 3'd0,
        ACT_INSERT   = 3'd1,
        ACT_DELETE   = 3'd2,
        ACT_RETARGET = 3'd3,
        ACT_CONFIRM  = 3'd4
    } rs_act_t;

endpackage

// File: rtl/btb_match.sv
// Associative search over the stored branch addresses.
// Does: compares a probe against every valid key and returns the per-entry
//       match vector, a hit flag and the index of the matching entry.
// Assumes: at most one valid entry matches (the table never duplicates keys).
module btb_match #(
    parameter int N     = 16,
    parameter int W     = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]        valid,
    input  logic [N-1:0][W-1:0] keys,
    input  logic [W-1:0]        probe,
    output logic [N-1:0]        hit_vec,
    output logic                hit,
    output logic [IDX_W-1:0]    idx
);

    // One full-width comparator per entry.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (keys[g] == probe);
    end

    assign hit = |hit_vec;

    // Encode the matching position into an index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/btb_victim.sv
// Allocation slot selection.
// Does: picks the lowest free entry; when none is free, picks the entry under
//       a round-robin pointer that advances after each overwrite.
// Assumes: alloc is asserted only in a cycle where an entry is written.
module btb_victim #(
    parameter int N     = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid,
    input  logic             alloc,
    output logic [IDX_W-1:0] victim
);

    logic [IDX_W-1:0] rr_ptr;
    logic             any_free;
    logic [IDX_W-1:0] free_idx;

    // Find the lowest-indexed invalid entry.
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // Free slot wins over the round-robin choice.
    assign victim = any_free ? free_idx : rr_ptr;

    // Advance the pointer only when a full table is overwritten.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (alloc && !any_free) begin
            rr_ptr <= (rr_ptr == IDX_W'(N - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/btb_core.sv
// Branch target buffer top.
// Does: same-cycle fetch lookup with full-address match, and a resolve port
//       that inserts, deletes, retargets or confirms entries while driving a
//       same-cycle redirect to the pipeline.
// Assumes: addresses are word aligned (sequential step is +4); one resolve
//          per cycle; a lookup in the same cycle as a resolve sees the old table.
module btb_core
    import btb_pkg::*;
#(
    parameter int N     = 16,
    parameter int PC_W  = 32,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  lk_pc,
    output logic             lk_hit,
    output logic [PC_W-1:0]  lk_next_pc,
    output logic [CNT_W-1:0] lk_state,
    input  logic             rs_valid,
    input  logic [PC_W-1:0]  rs_pc,
    input  logic             rs_taken,
    input  logic [PC_W-1:0]  rs_target,
    output logic             fl_redirect,
    output logic [PC_W-1:0]  fl_pc
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(1);
    localparam logic [PC_W-1:0]  PC_STEP  = PC_W'(4);

    // Table storage.
    logic [N-1:0]            ent_valid;
    logic [N-1:0][PC_W-1:0]  ent_pc;
    logic [N-1:0][PC_W-1:0]  ent_tgt;
    logic [N-1:0][CNT_W-1:0] ent_cnt;

    // Search results.
    logic [N-1:0]     fetch_hits;
    logic [IDX_W-1:0] fetch_idx;
    logic [N-1:0]     rs_hits;
    logic             rs_hit;
    logic [IDX_W-1:0] rs_idx;
    logic [IDX_W-1:0] victim;

    rs_act_t          act;
    logic [IDX_W-1:0] wr_idx;

    btb_match #(.N(N), .W(PC_W)) u_fetch_match (
        .valid   (ent_valid),
        .keys    (ent_pc),
        .probe   (lk_pc),
        .hit_vec (fetch_hits),
        .hit     (lk_hit),
        .idx     (fetch_idx)
    );

    btb_match #(.N(N), .W(PC_W)) u_rs_match (
        .valid   (ent_valid),
        .keys    (ent_pc),
        .probe   (rs_pc),
        .hit_vec (rs_hits),
        .hit     (rs_hit),
        .idx     (rs_idx)
    );

    btb_victim #(.N(N)) u_victim (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (ent_valid),
        .alloc  (act == ACT_INSERT),
        .victim (victim)
    );

    // Fetch outputs: stored target on a hit, sequential address otherwise.
    always_comb begin
        lk_next_pc = lk_hit ? ent_tgt[fetch_idx] : lk_pc + PC_STEP;
        lk_state   = lk_hit ? ent_cnt[fetch_idx] : '0;
    end

    // Classify the resolve update.
    always_comb begin
        act = ACT_NONE;
        if (rs_valid) begin
            if (rs_hit) begin
                if (!rs_taken)                      act = ACT_DELETE;
                else if (ent_tgt[rs_idx] != rs_target) act = ACT_RETARGET;
                else                                act = ACT_CONFIRM;
            end else if (rs_taken) begin
                act = ACT_INSERT;
            end
        end
    end

    // Redirect whenever the fetch that was made for this branch was wrong.
    always_comb begin
        fl_redirect = (act == ACT_INSERT) || (act == ACT_DELETE) ||
                      (act == ACT_RETARGET);
        fl_pc       = (act == ACT_DELETE) ? rs_pc + PC_STEP : rs_target;
        wr_idx      = (act == ACT_INSERT) ? victim : rs_idx;
    end

    // Apply the resolve action to the table.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_pc    <= '0;
            ent_tgt   <= '0;
            ent_cnt   <= '0;
        end else begin
            case (act)
                ACT_INSERT: begin
                    ent_valid[wr_idx] <= 1'b1;
                    ent_pc[wr_idx]    <= rs_pc;
                    ent_tgt[wr_idx]   <= rs_target;
                    ent_cnt[wr_idx]   <= CNT_INIT;
                end
                ACT_DELETE: begin
                    ent_valid[wr_idx] <= 1'b0;
                end
                ACT_RETARGET: begin
                    ent_tgt[wr_idx] <= rs_target;
                    ent_cnt[wr_idx] <= CNT_INIT;
                end
                ACT_CONFIRM: begin
                    if (ent_cnt[wr_idx] != CNT_MAX)
                        ent_cnt[wr_idx] <= ent_cnt[wr_idx] + 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/btb_chk.sv
// Property checker for btb_core, attached by bind.
// Does: checks reset emptiness, key uniqueness, resolve visibility and the
//       idle resolve port against the block's ports and match vectors.
// Assumes: synchronous active-low reset driven low from time zero.
module btb_chk #(
    parameter int N     = 16,
    parameter int PC_W  = 32,
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PC_W-1:0]  lk_pc,
    input logic             lk_hit,
    input logic [PC_W-1:0]  lk_next_pc,
    input logic [CNT_W-1:0] lk_state,
    input logic             rs_valid,
    input logic [PC_W-1:0]  rs_pc,
    input logic             rs_taken,
    input logic [PC_W-1:0]  rs_target,
    input logic             fl_redirect,
    input logic [N-1:0]     fetch_hits,
    input logic [N-1:0]     rs_hits
);

    AST_RESET_EMPTY: assert property (@(posedge clk) !rst_n |=> !lk_hit);  // R1

    AST_UNIQUE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fetch_hits) <= 1);  // R10

    AST_UNIQUE_RESOLVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rs_hits) <= 1);  // R10

    AST_TAKEN_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_taken) ##1 (lk_pc == $past(rs_pc))
        |-> (lk_hit && lk_next_pc == $past(rs_target)));  // R12

    AST_FALLTHRU_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_taken) ##1 (lk_pc == $past(rs_pc)) |-> !lk_hit);  // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |-> !fl_redirect);  // R11

    AST_HIT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_state != '0);  // R7

endmodule

bind btb_core btb_chk #(.N(N), .PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_pc       (lk_pc),
    .lk_hit      (lk_hit),
    .lk_next_pc  (lk_next_pc),
    .lk_state    (lk_state),
    .rs_valid    (rs_valid),
    .rs_pc       (rs_pc),
    .rs_taken    (rs_taken),
    .rs_target   (rs_target),
    .fl_redirect (fl_redirect),
    .fetch_hits  (fetch_hits),
    .rs_hits     (rs_hits)
);

// File: tb/tb_btb_core.sv
module tb_btb_core;

    localparam int N     = 16;
    localparam int PC_W  = 32;
    localparam int CNT_W = 2;
    localparam int POOL  = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PC_W-1:0]  lk_pc = '0;
    logic             lk_hit;
    logic [PC_W-1:0]  lk_next_pc;
    logic [CNT_W-1:0] lk_state;
    logic             rs_valid = 1'b0;
    logic [PC_W-1:0]  rs_pc = '0;
    logic             rs_taken = 1'b0;
    logic [PC_W-1:0]  rs_target = '0;
    logic             fl_redirect;
    logic [PC_W-1:0]  fl_pc;

    int n_checks = 0;
    int n_fails  = 0;

    // Bench model of the table.
    bit              m_valid [N];
    bit [PC_W-1:0]   m_pc    [N];
    bit [PC_W-1:0]   m_tgt   [N];
    bit [CNT_W-1:0]  m_cnt   [N];
    int              m_rr;

    bit [PC_W-1:0]   pool_pc [POOL];
    bit [PC_W-1:0]   pool_ta [POOL];
    bit [PC_W-1:0]   pool_tb [POOL];

    always #4 clk = ~clk;

    btb_core #(.N(N), .PC_W(PC_W), .CNT_W(CNT_W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_pc       (lk_pc),
        .lk_hit      (lk_hit),
        .lk_next_pc  (lk_next_pc),
        .lk_state    (lk_state),
        .rs_valid    (rs_valid),
        .rs_pc       (rs_pc),
        .rs_taken    (rs_taken),
        .rs_target   (rs_target),
        .fl_redirect (fl_redirect),
        .fl_pc       (fl_pc)
    );

    function automatic int m_find(bit [PC_W-1:0] pc);
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_pc[i] == pc) return i;
        return -1;
    endfunction

    function automatic int m_victim();
        for (int i = 0; i < N; i++)
            if (!m_valid[i]) return i;
        return -1;
    endfunction

    task automatic m_clear();
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_pc[i] = '0; m_tgt[i] = '0; m_cnt[i] = '0;
        end
        m_rr = 0;
    endtask

    task automatic chk(string req, string what, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Called just after a falling edge.
    task automatic do_lookup(bit [PC_W-1:0] pc, string tag);
        int i;
        bit eh;
        lk_pc = pc;
        #1;
        i  = m_find(pc);
        eh = (i >= 0);
        chk(tag != "" ? tag : (eh ? "R2" : "R3"), "hit", {31'd0, lk_hit}, {31'd0, eh});
        chk(tag != "" ? tag : (eh ? "R2" : "R3"), "next_pc", lk_next_pc,
            eh ? m_tgt[i] : pc + 32'd4);
        chk(eh ? "R7" : "R1", "state", PC_W'(lk_state), eh ? PC_W'(m_cnt[i]) : '0);
        @(negedge clk);
    endtask

    // Called just after a falling edge; ends just after the next falling edge.
    task automatic do_resolve(bit v, bit [PC_W-1:0] pc, bit tk, bit [PC_W-1:0] tg);
        int i;
        int w;
        bit er;
        bit [PC_W-1:0] ep;
        string tag;
        rs_valid = v; rs_pc = pc; rs_taken = tk; rs_target = tg;
        #1;
        i = m_find(pc);
        er = 0; ep = '0; tag = "R8";
        if (!v)                tag = "R11";
        else if (i >= 0 && !tk) begin er = 1; ep = pc + 32'd4; tag = "R5"; end
        else if (i >= 0 && m_tgt[i] != tg) begin er = 1; ep = tg; tag = "R6"; end
        else if (i >= 0)       tag = "R7";
        else if (tk)           begin er = 1; ep = tg; tag = "R4"; end
        chk(tag, "redirect", {31'd0, fl_redirect}, {31'd0, er});
        if (er) chk(tag, "fl_pc", fl_pc, ep);
        @(posedge clk);
        if (v) begin
            if (i >= 0 && !tk) m_valid[i] = 0;
            else if (i >= 0 && m_tgt[i] != tg) begin m_tgt[i] = tg; m_cnt[i] = 1; end
            else if (i >= 0) begin if (m_cnt[i] != 2'd3) m_cnt[i]++; end
            else if (tk) begin
                w = m_victim();
                if (w < 0) begin w = m_rr; m_rr = (m_rr + 1) % N; end
                m_valid[w] = 1; m_pc[w] = pc; m_tgt[w] = tg; m_cnt[w] = 1;
            end
        end
        @(negedge clk);
        rs_valid = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        @(posedge clk);
        m_clear();
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        #(8 * 150000);
        n_fails++;
        $display("FAIL watchdog expired, R1-R12 incomplete");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < POOL; i++) begin
            pool_pc[i] = (32'h0040_0000 ^ (i << 2) ^ (i << 24)) & ~32'h3;
            pool_ta[i] = $urandom() & ~32'h3;
            pool_tb[i] = $urandom() & ~32'h3;
        end
        m_clear();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: empty after reset
        do_lookup(pool_pc[0], "R1");
        do_lookup(32'h0, "R1");

        // R4 insert, R12 visible next cycle, R2 hit
        do_resolve(1, pool_pc[0], 1, pool_ta[0]);
        do_lookup(pool_pc[0], "R12");
        // R3: single-bit differences miss
        do_lookup(pool_pc[0] ^ 32'h4, "R3");
        do_lookup(pool_pc[0] ^ 32'h8000_0000, "R3");
        do_lookup(pool_pc[0] ^ 32'h0001_0000, "R3");
        // R7 confirm and saturation
        do_resolve(1, pool_pc[0], 1, pool_ta[0]);
        do_resolve(1, pool_pc[0], 1, pool_ta[0]);
        do_resolve(1, pool_pc[0], 1, pool_ta[0]);
        do_lookup(pool_pc[0], "R7");
        // R6 retarget
        do_resolve(1, pool_pc[0], 1, pool_tb[0]);
        do_lookup(pool_pc[0], "R6");
        // R11 idle resolve ignored
        do_resolve(0, pool_pc[1], 1, pool_ta[1]);
        do_lookup(pool_pc[1], "R11");
        do_resolve(0, pool_pc[0], 0, pool_ta[0]);
        do_lookup(pool_pc[0], "R11");
        // R8 not-taken miss
        do_resolve(1, pool_pc[2], 0, pool_ta[2]);
        do_lookup(pool_pc[2], "R8");
        // R5 delete
        do_resolve(1, pool_pc[0], 0, pool_ta[0]);
        do_lookup(pool_pc[0], "R5");

        // R9: fill, overwrite, hole, round-robin
        do_reset();
        for (int i = 0; i < N; i++) do_resolve(1, pool_pc[i], 1, pool_ta[i]);
        do_resolve(1, pool_pc[16], 1, pool_ta[16]);   // replaces entry 0
        do_lookup(pool_pc[0], "R9");
        do_lookup(pool_pc[16], "R9");
        do_resolve(1, pool_pc[5], 0, pool_ta[5]);     // hole at 5
        do_resolve(1, pool_pc[17], 1, pool_ta[17]);   // fills hole
        do_lookup(pool_pc[1], "R9");
        do_resolve(1, pool_pc[18], 1, pool_ta[18]);   // replaces entry 1
        do_lookup(pool_pc[1], "R9");
        do_lookup(pool_pc[17], "R9");
        do_lookup(pool_pc[2], "R9");

        // Random churn over all resolve cases
        for (int k = 0; k < 3000; k++) begin
            int p;
            int r;
            p = $urandom_range(POOL - 1);
            r = $urandom_range(99);
            if (r < 10)
                do_resolve(0, pool_pc[p], 1, pool_ta[p]);
            else if (r < 60)
                do_resolve(1, pool_pc[p], ($urandom_range(9) < 7),
                           $urandom_range(1) ? pool_ta[p] : pool_tb[p]);
            else
                do_lookup(r < 90 ? pool_pc[p] : pool_pc[p] ^ (32'h4 << $urandom_range(20)), "");
        end

        // R1: reset mid-run clears everything
        do_reset();
        for (int i = 0; i < POOL; i += 5) do_lookup(pool_pc[i], "R1");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule